// File: doc/BRIEF.md
# Radio Link Bring-Up Controller

This block sequences the start of a 2.4 GHz radio-control receiver front end. Right after reset it drives a reset pulse to the transceiver: the line stays high for a programmable number of cycles, then low for a second programmable number of cycles. It then asks a separate register command sequencer to perform one batch of register writes that configures the transceiver for operation. The bind input chooses the next mode. If binding is selected, the block issues a second, shorter batch that sets up bind reception. Otherwise it parks in the transfer-setup state.

The block talks to the sequencer through a simple request/ready handshake. The request carries the number of entries in the batch. Once the sequencer has accepted a batch, it fetches the (address, value) pairs one at a time through a combinational index port. The register tables are fixed contents inside the block. The current mode is exported as a 3-bit status code for telemetry.

Top module: `radio_bringup_ctrl`

## Requirements
- R1: While reset is asserted, the block shows status 0, `req_o` is low and `xcvr_rst_o` is high. The status codes are 0 uninitialised, 1 init-binding, 2 init-transfer, 3 binding and 4 transfer. Status never exceeds 4.
- R2: After reset is released, `xcvr_rst_o` stays high for exactly RST_HI_CYC rising edges and then stays low. `req_o` stays low until RST_LO_CYC further rising edges have elapsed. `xcvr_rst_o` never rises again.
- R3: Once the pulse is over, in status 0 the block holds `req_o` high with `req_len_o` = 11 until the request is accepted.
- R4: A request is accepted only on a rising edge where `req_o` and `seq_ready_i` are both high. When it is not accepted, the status is unchanged and the request stays high on the next cycle.
- R5: When the status-0 request is accepted, the status becomes 1 if `bind_i` is 0 on the accept edge, and 2 otherwise. The change is visible after that edge.
- R6: In status 1 the block holds `req_o` high with `req_len_o` = 5. When that request is accepted, the status becomes 3.
- R7: Statuses 2 and 3 are final. `req_o` stays low, and neither `seq_ready_i` nor `bind_i` changes the status.
- R8: Until the binding batch has been accepted, `tbl_idx_i` values 0..10 return these (address, value) pairs in this order: 1D/01, 28/02, 32/3C, 35/14, 06/48, 1B/55, 1C/05, 0F/2C, 03/3F, 12/0E, 0F/0C.
- R9: After the binding batch has been accepted, `tbl_idx_i` values 0..4 return these pairs in this order: 03/3F, 10/4E, 1E/14, 14/02, 1F/04.
- R10: An index at or beyond the length of the active table returns address 00 and value 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bind_i | input | 1 | Mode select sampled on the startup accept edge; 0 selects binding |
| seq_ready_i | input | 1 | Sequencer is idle and takes the pending request on this edge |
| tbl_idx_i | input | IDX_W | Entry index the sequencer fetches from the active table |
| xcvr_rst_o | output | 1 | Transceiver reset line |
| req_o | output | 1 | Batch write request toward the sequencer |
| req_len_o | output | IDX_W | Number of entries in the requested batch; 0 when no request is pending |
| tbl_addr_o | output | 8 | Register address of the indexed entry |
| tbl_data_o | output | 8 | Register value of the indexed entry |
| status_o | output | 3 | Current mode code |

## Verification
The table port is combinational, so a pair is sampled one time step after the index changes, within the same cycle. The request and its length follow the state register without delay. A status change therefore shows up after exactly one rising edge: the bench raises `seq_ready_i` at a falling edge and compares the status at the next falling edge. The reset line falls on rising edge RST_HI_CYC after release, and the first request appears on edge RST_HI_CYC + RST_LO_CYC. The bench counts edges from release and samples the cycle just before and just after each of these points, so that an off-by-one error in either counter is caught.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    localparam int REG_W       = 8;
    localparam int STARTUP_LEN = 11;
    localparam int BIND_LEN    = 5;

    typedef enum logic [2:0] {
        LS_UNINIT    = 3'd0,
        LS_INIT_BIND = 3'd1,
        LS_INIT_XFER = 3'd2,
        LS_BIND      = 3'd3,
        LS_XFER      = 3'd4
    } link_state_t;

    typedef enum logic [1:0] {
        PH_HOLD_HI = 2'd0,
        PH_HOLD_LO = 2'd1,
        PH_RUN     = 2'd2
    } pulse_phase_t;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
    } reg_pair_t;

    // Power-up configuration batch
    function automatic reg_pair_t startup_pair(input int unsigned i);
        reg_pair_t p;
        case (i)
            0:       p = '{addr: 8'h1D, data: 8'h01};
            1:       p = '{addr: 8'h28, data: 8'h02};
            2:       p = '{addr: 8'h32, data: 8'h3C};
            3:       p = '{addr: 8'h35, data: 8'h14};
            4:       p = '{addr: 8'h06, data: 8'h48};
            5:       p = '{addr: 8'h1B, data: 8'h55};
            6:       p = '{addr: 8'h1C, data: 8'h05};
            7:       p = '{addr: 8'h0F, data: 8'h2C};
            8:       p = '{addr: 8'h03, data: 8'h3F};
            9:       p = '{addr: 8'h12, data: 8'h0E};
            10:      p = '{addr: 8'h0F, data: 8'h0C};
            default: p = '0;
        endcase
        return p;
    endfunction

    // Bind reception batch
    function automatic reg_pair_t bind_pair(input int unsigned i);
        reg_pair_t p;
        case (i)
            0:       p = '{addr: 8'h03, data: 8'h3F};
            1:       p = '{addr: 8'h10, data: 8'h4E};
            2:       p = '{addr: 8'h1E, data: 8'h14};
            3:       p = '{addr: 8'h14, data: 8'h02};
            4:       p = '{addr: 8'h1F, data: 8'h04};
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rbc_reset_pulse.sv
module rbc_reset_pulse
    import rbc_pkg::*;
#(
    parameter int HI_CYC = 16,
    parameter int LO_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic xcvr_rst_o,
    output logic run_o
);

    localparam int MAX_CYC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(LO_CYC - 1);

    typedef struct packed {
        pulse_phase_t     ph;
        logic [CNT_W-1:0] cnt;
    } pulse_regs_t;

    pulse_regs_t pr_d, pr_q;

    always_comb begin
        pr_d = pr_q;
        case (pr_q.ph)
            PH_HOLD_HI: begin
                if (pr_q.cnt == HI_LAST) begin
                    pr_d.ph  = PH_HOLD_LO;
                    pr_d.cnt = '0;
                end else begin
                    pr_d.cnt = pr_q.cnt + 1'b1;
                end
            end
            PH_HOLD_LO: begin
                if (pr_q.cnt == LO_LAST) begin
                    pr_d.ph  = PH_RUN;
                    pr_d.cnt = '0;
                end else begin
                    pr_d.cnt = pr_q.cnt + 1'b1;
                end
            end
            default: pr_d = pr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_q <= '{ph: PH_HOLD_HI, cnt: '0};
        end else begin
            pr_q <= pr_d;
        end
    end

    assign xcvr_rst_o = (pr_q.ph == PH_HOLD_HI);
    assign run_o      = (pr_q.ph == PH_RUN);

endmodule

// File: rtl/rbc_mode_fsm.sv
module rbc_mode_fsm
    import rbc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             seq_ready_i,
    input  logic             bind_i,
    output logic             req_o,
    output logic [IDX_W-1:0] req_len_o,
    output logic             tbl_sel_o,
    output logic [2:0]       status_o
);

    localparam logic [IDX_W-1:0] LEN_STARTUP = IDX_W'(STARTUP_LEN);
    localparam logic [IDX_W-1:0] LEN_BIND    = IDX_W'(BIND_LEN);

    typedef struct packed {
        link_state_t st;
        logic        tbl_sel;
    } fsm_regs_t;

    fsm_regs_t fr_d, fr_q;
    logic      want_req;
    logic      accept;

    always_comb begin
        fr_d     = fr_q;
        want_req = run_i && (fr_q.st == LS_UNINIT || fr_q.st == LS_INIT_BIND);
        accept   = want_req && seq_ready_i;
        case (fr_q.st)
            LS_UNINIT: begin
                if (accept) begin
                    fr_d.st = bind_i ? LS_INIT_XFER : LS_INIT_BIND;
                end
            end
            LS_INIT_BIND: begin
                if (accept) begin
                    fr_d.st      = LS_BIND;
                    fr_d.tbl_sel = 1'b1;
                end
            end
            default: fr_d = fr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{st: LS_UNINIT, tbl_sel: 1'b0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign req_o     = want_req;
    assign req_len_o = !want_req ? '0 :
                       (fr_q.st == LS_INIT_BIND) ? LEN_BIND : LEN_STARTUP;
    assign tbl_sel_o = fr_q.tbl_sel;
    assign status_o  = fr_q.st;

endmodule

// File: rtl/rbc_reg_tables.sv
module rbc_reg_tables
    import rbc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             tbl_sel_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [REG_W-1:0] addr_o,
    output logic [REG_W-1:0] data_o
);

    reg_pair_t pair;

    always_comb begin
        if (tbl_sel_i) begin
            pair = bind_pair(int'(idx_i));
        end else begin
            pair = startup_pair(int'(idx_i));
        end
    end

    assign addr_o = pair.addr;
    assign data_o = pair.data;

endmodule

// File: rtl/radio_bringup_ctrl.sv
module radio_bringup_ctrl #(
    parameter int RST_HI_CYC = 16,
    parameter int RST_LO_CYC = 16,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bind_i,
    input  logic             seq_ready_i,
    input  logic [IDX_W-1:0] tbl_idx_i,
    output logic             xcvr_rst_o,
    output logic             req_o,
    output logic [IDX_W-1:0] req_len_o,
    output logic [7:0]       tbl_addr_o,
    output logic [7:0]       tbl_data_o,
    output logic [2:0]       status_o
);

    logic run;
    logic tbl_sel;

    rbc_reset_pulse #(
        .HI_CYC (RST_HI_CYC),
        .LO_CYC (RST_LO_CYC)
    ) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .xcvr_rst_o (xcvr_rst_o),
        .run_o      (run)
    );

    rbc_mode_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .seq_ready_i (seq_ready_i),
        .bind_i      (bind_i),
        .req_o       (req_o),
        .req_len_o   (req_len_o),
        .tbl_sel_o   (tbl_sel),
        .status_o    (status_o)
    );

    rbc_reg_tables #(
        .IDX_W (IDX_W)
    ) u_tables (
        .tbl_sel_i (tbl_sel),
        .idx_i     (tbl_idx_i),
        .addr_o    (tbl_addr_o),
        .data_o    (tbl_data_o)
    );

endmodule

// File: rtl/rbc_checker.sv
module rbc_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bind_i,
    input logic             seq_ready_i,
    input logic             xcvr_rst_o,
    input logic             req_o,
    input logic [IDX_W-1:0] req_len_o,
    input logic [2:0]       status_o
);

    p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o <= 3'd4);

    p_pulse_blocks_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_rst_o |-> !req_o);

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(xcvr_rst_o));

    p_startup_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && status_o == 3'd0) |-> req_len_o == IDX_W'(11));

    p_reject_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !seq_ready_i) |=> ($stable(status_o) && req_o));

    p_branch_bind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && seq_ready_i && status_o == 3'd0 && !bind_i) |=> status_o == 3'd1);

    p_branch_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && seq_ready_i && status_o == 3'd0 && bind_i) |=> status_o == 3'd2);

    p_bind_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && status_o == 3'd1) |-> req_len_o == IDX_W'(5));

    p_bind_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && seq_ready_i && status_o == 3'd1) |=> status_o == 3'd3);

    p_final_states_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'd2 || status_o == 3'd3) |=> ($stable(status_o) && !req_o));

endmodule

bind radio_bringup_ctrl rbc_checker #(
    .IDX_W (IDX_W)
) u_rbc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bind_i      (bind_i),
    .seq_ready_i (seq_ready_i),
    .xcvr_rst_o  (xcvr_rst_o),
    .req_o       (req_o),
    .req_len_o   (req_len_o),
    .status_o    (status_o)
);

// File: tb/test_radio_bringup_ctrl.sv
module test_radio_bringup_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HI_CYC     = 5;
    localparam int LO_CYC     = 3;
    localparam int IDX_W      = 4;
    localparam int NVEC       = 20;

    typedef struct packed {
        logic       sel;
        logic [3:0] idx;
        logic [7:0] a;
        logic [7:0] d;
    } vec_t;

    // sel 0: startup table (R8), sel 1: bind table (R9); zero rows for R10
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'd0,  8'h1D, 8'h01}, '{1'b0, 4'd1,  8'h28, 8'h02},
        '{1'b0, 4'd2,  8'h32, 8'h3C}, '{1'b0, 4'd3,  8'h35, 8'h14},
        '{1'b0, 4'd4,  8'h06, 8'h48}, '{1'b0, 4'd5,  8'h1B, 8'h55},
        '{1'b0, 4'd6,  8'h1C, 8'h05}, '{1'b0, 4'd7,  8'h0F, 8'h2C},
        '{1'b0, 4'd8,  8'h03, 8'h3F}, '{1'b0, 4'd9,  8'h12, 8'h0E},
        '{1'b0, 4'd10, 8'h0F, 8'h0C}, '{1'b0, 4'd11, 8'h00, 8'h00},
        '{1'b0, 4'd15, 8'h00, 8'h00},
        '{1'b1, 4'd0,  8'h03, 8'h3F}, '{1'b1, 4'd1,  8'h10, 8'h4E},
        '{1'b1, 4'd2,  8'h1E, 8'h14}, '{1'b1, 4'd3,  8'h14, 8'h02},
        '{1'b1, 4'd4,  8'h1F, 8'h04}, '{1'b1, 4'd5,  8'h00, 8'h00},
        '{1'b1, 4'd15, 8'h00, 8'h00}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bind_i = 1'b1;
    logic             seq_ready_i = 1'b0;
    logic [IDX_W-1:0] tbl_idx_i = '0;
    logic             xcvr_rst_o;
    logic             req_o;
    logic [IDX_W-1:0] req_len_o;
    logic [7:0]       tbl_addr_o;
    logic [7:0]       tbl_data_o;
    logic [2:0]       status_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    radio_bringup_ctrl #(
        .RST_HI_CYC (HI_CYC),
        .RST_LO_CYC (LO_CYC),
        .IDX_W      (IDX_W)
    ) i_radio_bringup_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bind_i      (bind_i),
        .seq_ready_i (seq_ready_i),
        .tbl_idx_i   (tbl_idx_i),
        .xcvr_rst_o  (xcvr_rst_o),
        .req_o       (req_o),
        .req_len_o   (req_len_o),
        .tbl_addr_o  (tbl_addr_o),
        .tbl_data_o  (tbl_data_o),
        .status_o    (status_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic sel, input string tag);
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].sel == sel) begin
                tbl_idx_i = VECS[v].idx;
                #1;
                chk({tag, " addr"}, 32'(tbl_addr_o), 32'(VECS[v].a));
                chk({tag, " data"}, 32'(tbl_data_o), 32'(VECS[v].d));
            end
        end
    endtask

    // Apply reset, release it and count edges up to the first request (R1, R2, R3)
    task automatic reset_and_pulse();
        rst_n = 1'b0;
        seq_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 status in reset", 32'(status_o), 32'd0);
        chk("R1 req in reset", 32'(req_o), 32'd0);
        chk("R1 xcvr_rst in reset", 32'(xcvr_rst_o), 32'd1);
        rst_n = 1'b1;
        for (int k = 1; k <= HI_CYC + LO_CYC; k++) begin
            @(negedge clk);
            if (k == HI_CYC - 1) chk("R2 xcvr_rst still high", 32'(xcvr_rst_o), 32'd1);
            if (k == HI_CYC)     chk("R2 xcvr_rst low", 32'(xcvr_rst_o), 32'd0);
            if (k == HI_CYC + LO_CYC - 1) chk("R2 no early req", 32'(req_o), 32'd0);
        end
        chk("R2 xcvr_rst stays low", 32'(xcvr_rst_o), 32'd0);
        chk("R3 req raised", 32'(req_o), 32'd1);
        chk("R3 startup length", 32'(req_len_o), 32'd11);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Vector walk over the startup table after a transfer branch
        bind_i = 1'b1;
        reset_and_pulse();
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R4 reject keeps status", 32'(status_o), 32'd0);
            chk("R4 reject keeps req", 32'(req_o), 32'd1);
        end
        seq_ready_i = 1'b1;
        @(negedge clk);
        chk("R5 bind=1 gives init-transfer", 32'(status_o), 32'd2);
        chk("R7 no req in init-transfer", 32'(req_o), 32'd0);
        bind_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 init-transfer holds", 32'(status_o), 32'd2);
        chk("R7 req length idle", 32'(req_len_o), 32'd0);
        walk(1'b0, "R8 R10 startup");

        // Binding branch
        bind_i = 1'b1;
        reset_and_pulse();
        seq_ready_i = 1'b1;
        bind_i = 1'b0;
        @(negedge clk);
        chk("R5 bind=0 gives init-binding", 32'(status_o), 32'd1);
        chk("R6 bind req high", 32'(req_o), 32'd1);
        chk("R6 bind length", 32'(req_len_o), 32'd5);
        seq_ready_i = 1'b0;
        bind_i = 1'b1;
        walk(1'b0, "R8 startup before bind accept");
        repeat (2) @(negedge clk);
        chk("R4 bind reject keeps status", 32'(status_o), 32'd1);
        seq_ready_i = 1'b1;
        @(negedge clk);
        chk("R6 binding entered", 32'(status_o), 32'd3);
        chk("R7 no req in binding", 32'(req_o), 32'd0);
        bind_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 binding holds", 32'(status_o), 32'd3);
        walk(1'b1, "R9 R10 bind");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule